// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable stand-in for the device end of a serial EEPROM that uses a chip select, a serial clock, a serial data input and a serial data output. It holds a word array (64 words of 16 bits by default, or 256 words when `ADDR_W` is 8). A host controller on the same chip, or a test fixture, can talk to it exactly as it would talk to an external part. All four serial pins are sampled with the system clock `clk_i`. The serial clock must therefore run well below the system clock, with each level held for at least two system clocks.

A command starts with a 1 bit while chip select is high. A 2-bit opcode follows, then the word address, both most significant bit first. Opcode `10` reads, opcode `01` writes and opcode `11` erases one word. Opcode `00` is an extended group, and the two top address bits pick its command: enable programming, disable programming, erase the whole array, or fill the whole array.

A read returns a leading 0 followed by the word. An accepted programming command turns the data pin into a status flag. The flag is low for `BUSY_CYCLES` system clocks and then goes high. Dropping chip select abandons any command in progress.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, do_o is 0, every word reads 16'hFFFF and programming is disabled.
- R2: di_i is sampled on each rising edge of sk_i while cs_i is high. Zeros before the first 1 are ignored. The bit order is: start bit 1, a 2-bit opcode, then ADDR_W address bits, all MSB first.
- R3: Opcode 10 is a read. After the rising edge that takes the last address bit, do_o is 0 (the dummy bit). Each later rising edge then presents the next bit of the addressed word, MSB first. After bit 0, do_o stays 0.
- R4: Opcode 01 is a write. The address is followed by 16 data bits, MSB first. The word is stored on the rising edge that takes the last data bit.
- R5: Opcode 11 is an erase. It sets the addressed word to 16'hFFFF on the edge that takes the last address bit, and no other word changes.
- R6: With opcode 00, the top two address bits select the command: 11 enables programming and 00 disables it. The other address bits have no effect.
- R7: With opcode 00 and top address bits 10, every word is set to 16'hFFFF. With opcode 00 and top address bits 01, the 16 data bits that follow are stored in every word.
- R8: While programming is disabled, a write, erase, erase-all or fill command leaves every word unchanged and produces no busy period.
- R9: After an accepted programming command, do_o stays 0 for BUSY_CYCLES system clocks from the committing edge and then reads 1, for as long as cs_i stays high.
- R10: While cs_i is low, do_o is 0. A command cut short by cs_i going low has no effect, and the next command needs a new start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data from the host |
| do_o | output | 1 | Serial read data or ready/busy flag |

## Verification
The checker covers the following on every cycle:
- the control state returns to idle one clock after chip select drops;
- no array write strobe fires while programming is locked;
- the busy counter counts down one per clock unless a new programming command reloads it;
- the first output after a read is loaded is the dummy 0;
- the status flag is high exactly when the counter has expired.

Some behaviour only the bench scenarios can show, because it depends on what the array holds across commands:
- that the stored word comes back bit by bit in the right order;
- that erase touches only the addressed word;
- that write-all and erase-all cover every address, including the last;
- that locked commands and aborted commands leave the contents intact.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_OPC    = 3'd1,
    ST_ADDR   = 3'd2,
    ST_DATA   = 3'd3,
    ST_READ   = 3'd4,
    ST_STATUS = 3'd5,
    ST_HOLD   = 3'd6
  } mw_state_e;

  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } mw_op_e;

  // extended group, selected by the two address MSBs
  typedef enum logic [1:0] {
    EX_LOCK   = 2'b00,
    EX_FILL   = 2'b01,
    EX_CLEAR  = 2'b10,
    EX_UNLOCK = 2'b11
  } mw_ext_e;
endpackage

// File: rtl/mw_cmd_fsm.sv
module mw_cmd_fsm
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sk_i,
  input  logic              di_i,
  output mw_state_e         state_o,
  output logic              sk_rise_o,
  output logic              prog_en_o,
  output logic              we_one_o,
  output logic              we_all_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  localparam int MAX_LEN = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int CNT_W   = $clog2(MAX_LEN) + 1;
  localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_END = CNT_W'(DATA_W - 1);

  logic              sk_q;
  logic              rise;
  mw_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q, addr_nxt;
  logic [DATA_W-1:0] data_q, data_nxt;
  logic              prog_en_q;
  logic              addr_last, data_last;
  mw_op_e            op;
  mw_ext_e           ext;
  logic              unlock_hit, lock_hit;

  assign rise      = cs_i & sk_i & ~sk_q;
  assign addr_nxt  = {addr_q[ADDR_W-2:0], di_i};
  assign data_nxt  = {data_q[DATA_W-2:0], di_i};
  assign addr_last = rise && (state_q == ST_ADDR) && (cnt_q == ADDR_END);
  assign data_last = rise && (state_q == ST_DATA) && (cnt_q == DATA_END);
  assign op        = mw_op_e'(op_q);
  assign ext       = mw_ext_e'(addr_nxt[ADDR_W-1 -: 2]);
  assign unlock_hit = addr_last && (op == OP_EXT) && (ext == EX_UNLOCK);
  assign lock_hit   = addr_last && (op == OP_EXT) && (ext == EX_LOCK);

  always_comb begin
    state_d = state_q;
    if (rise) begin
      unique case (state_q)
        ST_IDLE: if (di_i) state_d = ST_OPC;
        ST_OPC:  if (cnt_q == CNT_W'(1)) state_d = ST_ADDR;
        ST_ADDR: begin
          if (cnt_q == ADDR_END) begin
            unique case (op)
              OP_READ:  state_d = ST_READ;
              OP_WRITE: state_d = ST_DATA;
              OP_ERASE: state_d = prog_en_q ? ST_STATUS : ST_HOLD;
              OP_EXT: begin
                unique case (ext)
                  EX_FILL:  state_d = ST_DATA;
                  EX_CLEAR: state_d = prog_en_q ? ST_STATUS : ST_HOLD;
                  default:  state_d = ST_HOLD;
                endcase
              end
              default: state_d = ST_HOLD;
            endcase
          end
        end
        ST_DATA: if (cnt_q == DATA_END) state_d = prog_en_q ? ST_STATUS : ST_HOLD;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sk_q <= 1'b0;
    end else begin
      sk_q <= sk_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      op_q    <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (!cs_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (rise) begin
        cnt_q <= (state_d != state_q) ? '0 : cnt_q + CNT_W'(1);
        unique case (state_q)
          ST_OPC:  op_q   <= {op_q[0], di_i};
          ST_ADDR: addr_q <= addr_nxt;
          ST_DATA: data_q <= data_nxt;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_en_q <= 1'b0;
    end else if (unlock_hit) begin
      prog_en_q <= 1'b1;
    end else if (lock_hit) begin
      prog_en_q <= 1'b0;
    end
  end

  // erase commits at the last address bit, write at the last data bit
  assign we_one_o  = prog_en_q && ((addr_last && (op == OP_ERASE)) ||
                                   (data_last && (op == OP_WRITE)));
  assign we_all_o  = prog_en_q && ((addr_last && (op == OP_EXT) && (ext == EX_CLEAR)) ||
                                   (data_last && (op == OP_EXT)));
  assign wr_addr_o = (state_q == ST_ADDR) ? addr_nxt : addr_q;
  assign wr_data_o = (state_q == ST_DATA) ? data_nxt : '1;
  assign rd_req_o  = addr_last && (op == OP_READ);
  assign rd_addr_o = addr_nxt;
  assign state_o   = state_q;
  assign sk_rise_o = rise;
  assign prog_en_o = prog_en_q;
endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_one_i,
  input  logic              we_all_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] words [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [DATA_W-1:0] word_q;
    logic              hit;
    assign hit = we_all_i || (we_one_i && (wr_addr_i == ADDR_W'(g)));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q <= '1;
      end else if (hit) begin
        word_q <= wr_data_i;
      end
    end
    assign words[g] = word_q;
  end

  assign rd_data_o = words[rd_addr_i];
endmodule

// File: rtl/mw_status_out.sv
module mw_status_out
  import mw_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 8,
  parameter int BUSY_W      = $clog2(BUSY_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sk_rise_i,
  input  mw_state_e         state_i,
  input  logic              rd_req_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              prog_start_i,
  output logic [BUSY_W-1:0] busy_cnt_o,
  output logic              do_o
);
  logic [DATA_W:0]   sh_q;
  logic [BUSY_W-1:0] busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
    end else if (rd_req_i) begin
      sh_q <= {1'b0, rd_data_i};   // dummy zero leads the word
    end else if (sk_rise_i && (state_i == ST_READ)) begin
      sh_q <= {sh_q[DATA_W-1:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= '0;
    end else if (prog_start_i) begin
      busy_q <= BUSY_W'(BUSY_CYCLES);
    end else if (busy_q != '0) begin
      busy_q <= busy_q - BUSY_W'(1);
    end
  end

  assign busy_cnt_o = busy_q;
  assign do_o = cs_i && (((state_i == ST_READ) && sh_q[DATA_W]) ||
                         ((state_i == ST_STATUS) && (busy_q == '0)));
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o
);
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

  mw_state_e         state;
  logic              sk_rise;
  logic              prog_en;
  logic              we_one, we_all;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic              rd_req;
  logic [BUSY_W-1:0] busy_cnt;

  mw_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_i      (cs_i),
    .sk_i      (sk_i),
    .di_i      (di_i),
    .state_o   (state),
    .sk_rise_o (sk_rise),
    .prog_en_o (prog_en),
    .we_one_o  (we_one),
    .we_all_o  (we_all),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .rd_req_o  (rd_req),
    .rd_addr_o (rd_addr)
  );

  mw_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_one_i  (we_one),
    .we_all_i  (we_all),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  mw_status_out #(.DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES), .BUSY_W(BUSY_W)) i_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_i         (cs_i),
    .sk_rise_i    (sk_rise),
    .state_i      (state),
    .rd_req_i     (rd_req),
    .rd_data_i    (rd_data),
    .prog_start_i (we_one | we_all),
    .busy_cnt_o   (busy_cnt),
    .do_o         (do_o)
  );
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
  import mw_pkg::*;
#(
  parameter int BUSY_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_i,
  input logic              do_o,
  input mw_state_e         state,
  input logic              prog_en,
  input logic              we_one,
  input logic              we_all,
  input logic              rd_req,
  input logic [BUSY_W-1:0] busy_cnt
);
  a_r10_cs_low_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> (state == ST_IDLE));

  a_r8_locked_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_en |-> !(we_one || we_all));

  a_r9_busy_counts_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((busy_cnt != '0) && !(we_one || we_all)) |=> (busy_cnt == $past(busy_cnt) - BUSY_W'(1)));

  a_r9_ready_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && (state == ST_STATUS)) |-> (do_o == (busy_cnt == '0)));

  a_r3_dummy_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> !do_o);

  a_r7_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({we_one, we_all}));
endmodule

bind mw_eeprom mw_eeprom_chk #(.BUSY_W(BUSY_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_i     (cs_i),
  .do_o     (do_o),
  .state    (state),
  .prog_en  (prog_en),
  .we_one   (we_one),
  .we_all   (we_all),
  .rd_req   (rd_req),
  .busy_cnt (busy_cnt)
);

// File: tb/test_mw_eeprom.sv
`timescale 1ns/1ps
module test_mw_eeprom;
  localparam int AW    = 6;
  localparam int WORDS = 1 << AW;
  localparam int BUSY  = 8;
  localparam int HALF  = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_o;

  int checks = 0;
  int fails  = 0;

  mw_eeprom #(.ADDR_W(AW), .DATA_W(16), .BUSY_CYCLES(BUSY)) i_mw_eeprom (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cs_i  (cs),
    .sk_i  (sk),
    .di_i  (di),
    .do_o  (do_o)
  );

  always #2.5 clk_i = ~clk_i;

  // behavioural reference
  int         m_state = 0;   // 0 idle 1 collect 2 read 3 status 4 hold
  bit         m_en = 1'b0;
  logic [15:0] m_mem [WORDS];
  bit         bits_q[$];
  bit         out_q[$];
  int         m_busy = 0;
  bit         sk_prev = 1'b0;
  int         m_op, m_addr;
  bit         run_done = 1'b0;

  initial for (int i = 0; i < WORDS; i++) m_mem[i] = 16'hFFFF;

  function automatic void m_prog(bit all, int a, logic [15:0] v);
    if (m_en) begin
      if (all) begin
        for (int i = 0; i < WORDS; i++) m_mem[i] = v;
      end else begin
        m_mem[a] = v;
      end
      m_busy  = BUSY;
      m_state = 3;
    end else begin
      m_state = 4;
    end
  endfunction

  function automatic void m_step();
    int n;
    logic [15:0] d;
    if (m_busy > 0) m_busy--;
    if (!cs) begin
      m_state = 0;
      bits_q.delete();
      out_q.delete();
    end else if (sk && !sk_prev) begin
      case (m_state)
        0: if (di) m_state = 1;
        1: begin
          bits_q.push_back(di);
          n = bits_q.size();
          if (n == 2 + AW) begin
            m_op = bits_q[0] * 2 + bits_q[1];
            m_addr = 0;
            for (int i = 2; i < n; i++) m_addr = m_addr * 2 + bits_q[i];
            case (m_op)
              2: begin
                out_q.delete();
                out_q.push_back(1'b0);
                for (int b = 15; b >= 0; b--) out_q.push_back(m_mem[m_addr][b]);
                m_state = 2;
              end
              3: m_prog(0, m_addr, 16'hFFFF);
              0: begin
                case (m_addr >> (AW - 2))
                  3: begin m_en = 1'b1; m_state = 4; end
                  0: begin m_en = 1'b0; m_state = 4; end
                  2: m_prog(1, 0, 16'hFFFF);
                  default: ;
                endcase
              end
              default: ;
            endcase
          end else if (n == 2 + AW + 16) begin
            d = '0;
            for (int i = 2 + AW; i < n; i++) d = {d[14:0], bits_q[i]};
            m_prog(m_op == 0, m_addr, d);
          end
        end
        2: if (out_q.size() > 0) void'(out_q.pop_front());
        default: ;
      endcase
    end
    sk_prev = sk;
  endfunction

  always @(posedge clk_i) begin
    bit exp_do;
    #1;
    if (rst_ni && !run_done) begin
      m_step();
      exp_do = cs && ((m_state == 2 && out_q.size() > 0 && out_q[0]) ||
                      (m_state == 3 && m_busy == 0));
      checks++;
      if (do_o !== exp_do) begin
        fails++;
        $display("FAIL %s per-cycle do_o actual %b expected %b at %0t",
                 (m_state == 2) ? "R3" : (m_state == 3) ? "R9" : "R10", do_o, exp_do, $time);
      end
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clk_bit(input bit b, output bit s);
    @(negedge clk_i);
    sk = 1'b0;
    di = b;
    repeat (HALF - 1) @(negedge clk_i);
    @(negedge clk_i);
    s  = do_o;
    sk = 1'b1;
    repeat (HALF - 1) @(negedge clk_i);
  endtask

  task automatic cs_on();
    @(negedge clk_i);
    cs = 1'b1;
    sk = 1'b0;
  endtask

  task automatic cs_off();
    @(negedge clk_i);
    cs = 1'b0;
    sk = 1'b0;
    di = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  // start bit, opcode, address; optional data; chip select left high
  task automatic send_cmd(bit [1:0] op, bit [AW-1:0] addr, bit has_data, bit [15:0] data);
    bit s;
    cs_on();
    clk_bit(1'b1, s);
    for (int i = 1; i >= 0; i--) clk_bit(op[i], s);
    for (int i = AW - 1; i >= 0; i--) clk_bit(addr[i], s);
    if (has_data) for (int i = 15; i >= 0; i--) clk_bit(data[i], s);
  endtask

  task automatic run_cmd(bit [1:0] op, bit [AW-1:0] addr, bit has_data, bit [15:0] data);
    send_cmd(op, addr, has_data, data);
    repeat (BUSY + 4) @(negedge clk_i);
    cs_off();
  endtask

  task automatic read_word(bit [AW-1:0] addr, output bit dummy, output bit [15:0] v);
    bit s;
    send_cmd(2'b10, addr, 1'b0, 16'h0);
    clk_bit(1'b0, dummy);
    v = '0;
    for (int i = 0; i < 16; i++) begin
      clk_bit(1'b0, s);
      v = {v[14:0], s};
    end
    cs_off();
  endtask

  task automatic expect_word(string tag, bit [AW-1:0] addr, bit [15:0] exp);
    bit dm;
    bit [15:0] v;
    read_word(addr, dm, v);
    chk(tag, v, exp);
  endtask

  task automatic finish_run();
    run_done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  localparam bit [AW-1:0] A_UNLOCK = {2'b11, {(AW-2){1'b0}}};
  localparam bit [AW-1:0] A_LOCK   = {2'b00, {(AW-2){1'b1}}};
  localparam bit [AW-1:0] A_CLEAR  = {2'b10, {(AW-2){1'b0}}};
  localparam bit [AW-1:0] A_FILL   = {2'b01, {(AW-2){1'b0}}};

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired actual running expected finished");
    finish_run();
  end

  initial begin
    bit dm, s;
    bit [15:0] v;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1 do_o after reset", {15'b0, do_o}, 16'h0);
    read_word(6'd7, dm, v);
    chk("R1 erased after reset", v, 16'hFFFF);
    chk("R3 dummy bit", {15'b0, dm}, 16'h0);

    // R8: locked write
    run_cmd(2'b01, 6'd5, 1'b1, 16'h1234);
    expect_word("R8 locked write ignored", 6'd5, 16'hFFFF);

    // R6: unlock with random don't-care bits
    run_cmd(2'b00, A_UNLOCK | 6'b00_1011, 1'b0, 16'h0);
    // R4 plus R9 directed busy observation
    send_cmd(2'b01, 6'd5, 1'b1, 16'hA5C3);
    chk("R9 busy low", {15'b0, do_o}, 16'h0);
    repeat (BUSY) @(negedge clk_i);
    chk("R9 ready high", {15'b0, do_o}, 16'h1);
    cs_off();
    chk("R10 do_o low with cs low", {15'b0, do_o}, 16'h0);
    expect_word("R4 write addr 5", 6'd5, 16'hA5C3);
    run_cmd(2'b01, 6'd63, 1'b1, 16'h8001);
    run_cmd(2'b01, 6'd0, 1'b1, 16'h7E5A);
    expect_word("R4 write top addr", 6'd63, 16'h8001);
    expect_word("R4 write addr 0", 6'd0, 16'h7E5A);

    // R2: leading zeros before start bit
    cs_on();
    clk_bit(1'b0, s);
    clk_bit(1'b0, s);
    clk_bit(1'b1, s);
    clk_bit(1'b1, s); clk_bit(1'b0, s);
    for (int i = AW - 1; i >= 0; i--) clk_bit(v[i] ^ v[i] ^ (6'd63 >> i) & 1'b1, s);
    clk_bit(1'b0, dm);
    v = '0;
    for (int i = 0; i < 16; i++) begin clk_bit(1'b0, s); v = {v[14:0], s}; end
    clk_bit(1'b0, s);
    chk("R2 leading zeros skipped", v, 16'h8001);
    chk("R3 zero after last bit", {15'b0, s}, 16'h0);
    cs_off();

    // R5: erase one word
    run_cmd(2'b11, 6'd5, 1'b0, 16'h0);
    expect_word("R5 erased word", 6'd5, 16'hFFFF);
    expect_word("R5 neighbour intact", 6'd0, 16'h7E5A);

    // R10: aborted write
    cs_on();
    clk_bit(1'b1, s);
    clk_bit(1'b0, s); clk_bit(1'b1, s);
    for (int i = AW - 1; i >= 0; i--) clk_bit(1'b0, s);
    for (int i = 0; i < 5; i++) clk_bit(1'b1, s);
    cs_off();
    expect_word("R10 aborted write", 6'd0, 16'h7E5A);

    // R7: fill then clear
    run_cmd(2'b00, A_FILL, 1'b1, 16'h3C96);
    expect_word("R7 fill addr 0", 6'd0, 16'h3C96);
    expect_word("R7 fill addr 33", 6'd33, 16'h3C96);
    expect_word("R7 fill addr 63", 6'd63, 16'h3C96);
    run_cmd(2'b00, A_CLEAR, 1'b0, 16'h0);
    expect_word("R7 clear addr 17", 6'd17, 16'hFFFF);
    expect_word("R7 clear addr 63", 6'd63, 16'hFFFF);

    // R6 lock, R8 erase/fill while locked
    run_cmd(2'b01, 6'd9, 1'b1, 16'h0F0F);
    run_cmd(2'b00, A_LOCK, 1'b0, 16'h0);
    run_cmd(2'b01, 6'd9, 1'b1, 16'h1111);
    run_cmd(2'b11, 6'd9, 1'b0, 16'h0);
    run_cmd(2'b00, A_FILL, 1'b1, 16'h2222);
    expect_word("R6 lock blocks write", 6'd9, 16'h0F0F);
    expect_word("R8 locked fill ignored", 6'd10, 16'hFFFF);

    repeat (5) @(negedge clk_i);
    finish_run();
  end
endmodule